// File: doc/BRIEF.md
# Serial Register Slave with Self-Selecting Clock Edges

This block is the serial front end of a converter's register bank. A host frames each transfer with an active-high select line and toggles a serial clock. The block does not take a configured clock mode. Instead, it reads the level of the serial clock at the moment the select line goes high. From that level it decides which clock edge launches its output bit and which edge captures the host's input bit. One shift register carries both directions, most significant bit first.

The first byte of every transfer is a command byte. Bit 7 set means write and bit 7 clear means read. Bits 6:0 give a start address. Each byte after it is written to, or read from, the current address, and the address then steps by one. Writes appear as a one-cycle strobe carrying the address and data. A read loads the byte for the next address into the shift register and raises a read strobe. The internal bank holds:

- the converter's eight results, split into high and low bytes;
- a status byte;
- three writable control bytes: channel select, start address and mode.

All serial inputs are resynchronised into the system clock. The system clock must run at least eight times faster than the serial clock.

Top module: `spi_autopol_slave`

## Requirements
- R1: After reset, `miso` and `miso_oe` are 0, both strobes are 0, and `chan_sel`, `start_addr` and `mode_sel` are 0x00.
- R2: The idle level captured when `cs` rises sets the edge behaviour for the whole transfer. It is captured again at every new transfer, so back-to-back transfers may use opposite idle levels.
- R3: If `sck` was low when `cs` rose, `miso` changes only after rising `sck` edges, and `mosi` is captured on falling edges.
- R4: If `sck` was high when `cs` rose, `miso` changes only after falling `sck` edges, and `mosi` is captured on rising edges.
- R5: Both directions move the most significant bit first. Command byte layout: bit 7 = 1 means write and 0 means read; bits 6:0 give the start address.
- R6: In a write transfer, each complete data byte raises `wr_stb` for one cycle. `reg_addr` carries the current address and `reg_wdata` carries the byte. The address then steps by one. Writes to 0x11, 0x12 and 0x13 update `chan_sel`, `start_addr` and `mode_sel`.
- R7: In a read transfer, data bytes are shifted out starting at the start address, and the address steps by one per byte. `rd_stb` pulses once per completed byte, including the command byte. Bits received during a read cause no write strobe.
- R8: Register map:
  - 0x00..0x07: result bits 9:2 of channels 0..7.
  - 0x08..0x0F: result bits 1:0 of channels 0..7, placed in bits 7:6, with bits 5:0 = 0.
  - 0x10: `status_in`.
  - 0x11..0x13: the three control bytes.
  - Any other address reads 0x00.
  - Writes to 0x00..0x10 do not change any readback.
- R9: Lowering `cs` part-way through a byte discards that byte with no strobe. The next transfer starts again with a command byte.
- R10: While `cs` is low, `miso_oe` is 0 and `miso` is 0. While `cs` is high during a transfer, `miso_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Active-high transfer select |
| sck | input | 1 | Serial clock from host |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| miso_oe | output | 1 | Drive enable for `miso` |
| res_data | input | 80 | Eight 10-bit conversion results, channel 0 in bits 9:0 |
| status_in | input | 8 | Status byte served at 0x10 |
| chan_sel | output | 8 | Channel select control byte |
| start_addr | output | 8 | Start address control byte |
| mode_sel | output | 8 | Mode control byte |
| wr_stb | output | 1 | One-cycle write strobe |
| rd_stb | output | 1 | One-cycle read-load strobe |
| reg_addr | output | 7 | Address of the current strobe |
| reg_wdata | output | 8 | Data of the current write strobe |

## Verification
A wrongly latched idle level swaps launch and capture. Within the first byte, every received bit then comes from the wrong half period, so the first write strobe carries a wrong address or data. On reads, `miso` is also seen moving during the capture half period. A wrong address counter shows at the next byte boundary, as a strobe with the wrong `reg_addr` or a read byte from the neighbouring register. A bit counter that does not clear on abort shows in the very next transfer, as a misframed command byte.

// File: rtl/autopol_pkg.sv
package autopol_pkg;
   typedef enum logic {
      IDLE_LOW  = 1'b0,
      IDLE_HIGH = 1'b1
   } idle_lvl_e;

   localparam int unsigned CTRL_SLOTS = 3;
endpackage

// File: rtl/autopol_sync.sv
module autopol_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("autopol_sync needs at least two stages");
   end

   logic [STAGES-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/autopol_frame.sv
module autopol_frame
   import autopol_pkg::*;
#(
   parameter int unsigned DW = 8,
   parameter int unsigned AW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_s,
   input  logic          sck_s,
   input  logic          mosi_s,
   input  logic [DW-1:0] rd_data,
   output logic [AW-1:0] rd_addr,
   output logic          wr_stb,
   output logic          rd_stb,
   output logic [AW-1:0] reg_addr,
   output logic [DW-1:0] reg_wdata,
   output logic          miso,
   output logic          miso_oe
);
   localparam int unsigned CW = $clog2(DW);
   localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);
   localparam logic [AW-1:0] ONE_A    = AW'(1);
   localparam logic [CW-1:0] ONE_C    = CW'(1);

   if (AW >= DW) begin : g_bad_aw
      $error("address must fit below the direction bit of the command byte");
   end

   logic          cs_q, sck_q;
   idle_lvl_e     pol;
   logic [CW-1:0] bitcnt;
   logic [DW-1:0] shreg;
   logic          first, rw;
   logic [AW-1:0] addr;

   logic          cs_rise, sck_rise, sck_fall, launch, capture, byte_done;
   logic [DW-1:0] rx_full;
   logic [AW-1:0] nxt_addr;
   logic          rw_next;

   always_comb begin
      cs_rise   = cs_s & ~cs_q;
      sck_rise  = sck_s & ~sck_q;
      sck_fall  = ~sck_s & sck_q;
      launch    = cs_s & cs_q & ((pol == IDLE_HIGH) ? sck_fall : sck_rise);
      capture   = cs_s & cs_q & ((pol == IDLE_HIGH) ? sck_rise : sck_fall);
      byte_done = capture && (bitcnt == LAST_BIT);
      rx_full   = {shreg[DW-2:0], mosi_s};
      nxt_addr  = first ? rx_full[AW-1:0] : addr + ONE_A;
      rw_next   = first ? rx_full[DW-1] : rw;
   end

   assign rd_addr = nxt_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q      <= 1'b0;
         sck_q     <= 1'b0;
         pol       <= IDLE_LOW;
         bitcnt    <= '0;
         shreg     <= '0;
         first     <= 1'b1;
         rw        <= 1'b0;
         addr      <= '0;
         wr_stb    <= 1'b0;
         rd_stb    <= 1'b0;
         reg_addr  <= '0;
         reg_wdata <= '0;
         miso      <= 1'b0;
         miso_oe   <= 1'b0;
      end else begin
         cs_q    <= cs_s;
         sck_q   <= sck_s;
         wr_stb  <= 1'b0;
         rd_stb  <= 1'b0;
         miso_oe <= cs_s;
         if (!cs_s) begin
            bitcnt <= '0;
            first  <= 1'b1;
            shreg  <= '0;
            miso   <= 1'b0;
         end else if (cs_rise) begin
            pol    <= idle_lvl_e'(sck_s);
            bitcnt <= '0;
            first  <= 1'b1;
            shreg  <= '0;
            miso   <= 1'b0;
         end else begin
            if (launch) miso <= shreg[DW-1];
            if (capture) begin
               if (byte_done) begin
                  bitcnt <= '0;
                  first  <= 1'b0;
                  rw     <= rw_next;
                  addr   <= nxt_addr;
                  shreg  <= rw_next ? '0 : rd_data;
                  rd_stb <= ~rw_next;
                  if (!first && rw) begin
                     wr_stb    <= 1'b1;
                     reg_addr  <= addr;
                     reg_wdata <= rx_full;
                  end else begin
                     reg_addr  <= nxt_addr;
                  end
               end else begin
                  bitcnt <= bitcnt + ONE_C;
                  shreg  <= rx_full;
               end
            end
         end
      end
   end

   AST_POL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cs_q) && cs_q && cs_s) |-> $stable(pol)); // R2
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_stb && rd_stb)); // R7
   AST_IDLE_MISO: assert property (@(posedge clk) disable iff (!rst_n)
      !miso_oe |-> !miso); // R10
   AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_s |=> (bitcnt == '0 && !wr_stb)); // R9
endmodule

// File: rtl/autopol_regbank.sv
module autopol_regbank
   import autopol_pkg::*;
#(
   parameter int unsigned NCH        = 8,
   parameter int unsigned RES_W      = 10,
   parameter int unsigned DW         = 8,
   parameter int unsigned AW         = 7,
   parameter bit          LEFT_ALIGN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NCH*RES_W-1:0] res_data,
   input  logic [DW-1:0]      status_in,
   input  logic               wr_stb,
   input  logic [AW-1:0]      wr_addr,
   input  logic [DW-1:0]      wr_data,
   input  logic [AW-1:0]      rd_addr,
   output logic [DW-1:0]      rd_data,
   output logic [DW-1:0]      chan_sel,
   output logic [DW-1:0]      start_addr,
   output logic [DW-1:0]      mode_sel
);
   localparam int unsigned LOW_BITS = RES_W - DW;
   localparam int unsigned IDXW     = (NCH > 1) ? $clog2(NCH) : 1;
   localparam logic [AW-1:0] A_NCH  = AW'(NCH);
   localparam logic [AW-1:0] A_LOW  = AW'(2 * NCH);
   localparam logic [AW-1:0] A_STAT = AW'(2 * NCH);
   localparam logic [AW-1:0] A_CFG0 = AW'(2 * NCH + 1);
   localparam logic [AW-1:0] A_CEND = AW'(2 * NCH + 1 + CTRL_SLOTS);

   if (RES_W <= DW || RES_W >= 2 * DW) begin : g_bad_res
      $error("result width must lie between one and two bytes");
   end
   if (2 * NCH + 1 + CTRL_SLOTS > (1 << AW)) begin : g_bad_space
      $error("register space exceeds the address width");
   end

   logic [DW-1:0] hi_b [NCH];
   logic [DW-1:0] lo_b [NCH];
   logic [DW-1:0] cfg  [CTRL_SLOTS];

   for (genvar ch = 0; ch < NCH; ch++) begin : g_res
      logic [RES_W-1:0] r;
      assign r        = res_data[ch*RES_W +: RES_W];
      assign hi_b[ch] = r[RES_W-1 -: DW];
      if (LEFT_ALIGN) begin : g_left
         assign lo_b[ch] = {r[LOW_BITS-1:0], {(DW-LOW_BITS){1'b0}}};
      end else begin : g_right
         assign lo_b[ch] = {{(DW-LOW_BITS){1'b0}}, r[LOW_BITS-1:0]};
      end
   end

   for (genvar k = 0; k < CTRL_SLOTS; k++) begin : g_cfg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cfg[k] <= '0;
         else if (wr_stb && wr_addr == A_CFG0 + AW'(k)) cfg[k] <= wr_data;
      end
   end

   always_comb begin
      logic [AW-1:0] off;
      off     = '0;
      rd_data = '0;
      if (rd_addr < A_NCH) begin
         rd_data = hi_b[rd_addr[IDXW-1:0]];
      end else if (rd_addr < A_LOW) begin
         off     = rd_addr - A_NCH;
         rd_data = lo_b[off[IDXW-1:0]];
      end else if (rd_addr == A_STAT) begin
         rd_data = status_in;
      end else if (rd_addr < A_CEND) begin
         off     = rd_addr - A_CFG0;
         rd_data = cfg[off[1:0]];
      end
   end

   assign chan_sel   = cfg[0];
   assign start_addr = cfg[1];
   assign mode_sel   = cfg[2];

   AST_RO_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && (wr_addr < A_CFG0)) |=>
         ($stable(chan_sel) && $stable(start_addr) && $stable(mode_sel))); // R8
endmodule

// File: rtl/spi_autopol_slave.sv
module spi_autopol_slave #(
   parameter int unsigned NCH         = 8,
   parameter int unsigned RES_W       = 10,
   parameter int unsigned DW          = 8,
   parameter int unsigned AW          = 7,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cs,
   input  logic                 sck,
   input  logic                 mosi,
   output logic                 miso,
   output logic                 miso_oe,
   input  logic [NCH*RES_W-1:0] res_data,
   input  logic [DW-1:0]        status_in,
   output logic [DW-1:0]        chan_sel,
   output logic [DW-1:0]        start_addr,
   output logic [DW-1:0]        mode_sel,
   output logic                 wr_stb,
   output logic                 rd_stb,
   output logic [AW-1:0]        reg_addr,
   output logic [DW-1:0]        reg_wdata
);
   logic cs_s, sck_s, mosi_s;
   logic [AW-1:0] rd_addr;
   logic [DW-1:0] rd_data;

   autopol_sync #(.STAGES(SYNC_STAGES)) u_sync_cs
      (.clk(clk), .rst_n(rst_n), .d(cs),   .q(cs_s));
   autopol_sync #(.STAGES(SYNC_STAGES)) u_sync_sck
      (.clk(clk), .rst_n(rst_n), .d(sck),  .q(sck_s));
   autopol_sync #(.STAGES(SYNC_STAGES)) u_sync_mosi
      (.clk(clk), .rst_n(rst_n), .d(mosi), .q(mosi_s));

   autopol_frame #(.DW(DW), .AW(AW)) u_frame (
      .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sck_s(sck_s), .mosi_s(mosi_s),
      .rd_data(rd_data), .rd_addr(rd_addr), .wr_stb(wr_stb), .rd_stb(rd_stb),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .miso(miso), .miso_oe(miso_oe)
   );

   autopol_regbank #(.NCH(NCH), .RES_W(RES_W), .DW(DW), .AW(AW), .LEFT_ALIGN(1'b1)) u_bank (
      .clk(clk), .rst_n(rst_n), .res_data(res_data), .status_in(status_in),
      .wr_stb(wr_stb), .wr_addr(reg_addr), .wr_data(reg_wdata),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .chan_sel(chan_sel), .start_addr(start_addr), .mode_sel(mode_sel)
   );
endmodule

// File: tb/spi_autopol_slave_tb.sv
module spi_autopol_slave_tb;
   localparam int HALF = 8;

   logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sck = 1'b0, mosi = 1'b0;
   logic miso, miso_oe, wr_stb, rd_stb;
   logic [79:0] res_data;
   logic [7:0]  status_in = 8'h5A;
   logic [7:0]  chan_sel, start_addr, mode_sel, reg_wdata;
   logic [6:0]  reg_addr;

   always #10 clk = ~clk;

   spi_autopol_slave u_dut (
      .clk(clk), .rst_n(rst_n), .cs(cs), .sck(sck), .mosi(mosi),
      .miso(miso), .miso_oe(miso_oe), .res_data(res_data), .status_in(status_in),
      .chan_sel(chan_sel), .start_addr(start_addr), .mode_sel(mode_sel),
      .wr_stb(wr_stb), .rd_stb(rd_stb), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
   );

   int n_chk = 0, n_fail = 0, rd_cnt = 0;
   bit done = 1'b0, edge_bad = 1'b0, oe_during = 1'b0;
   logic [14:0] exp_q[$];
   logic [7:0] tx_buf [16];
   logic [7:0] rx_buf [16];
   logic [7:0] mdl [3];

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_rd(input int a);
      logic [9:0] r;
      if (a < 8)       begin r = res_data[a*10 +: 10];     return r[9:2]; end
      else if (a < 16) begin r = res_data[(a-8)*10 +: 10]; return {r[1:0], 6'b0}; end
      else if (a == 16) return status_in;
      else if (a < 20)  return mdl[a-17];
      return 8'h00;
   endfunction

   // scoreboard monitor: write strobes against queued expectations
   always @(negedge clk) begin
      if (rd_stb) rd_cnt++;
      if (wr_stb) begin
         if (exp_q.size() == 0) check(1'b0, "R7 unexpected write", {reg_addr, reg_wdata}, 0);
         else begin
            logic [14:0] e;
            e = exp_q.pop_front();
            check({reg_addr, reg_wdata} == e, "R6 write strobe", {reg_addr, reg_wdata}, e);
         end
      end
   end

   task automatic push_wr(input int a, input logic [7:0] d);
      exp_q.push_back({7'(a), d});
      if (a >= 17 && a < 20) mdl[a-17] = d;
   endtask

   task automatic xfer(input bit p, input int n, input int cut);
      edge_bad = 1'b0;
      sck = p; cs = 1'b0;
      repeat (6) @(negedge clk);
      cs = 1'b1;
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         for (int b = 7; b >= 0; b--) begin
            logic m;
            if (i == n-1 && cut >= 0 && (7 - b) >= cut) break;
            sck = ~p; mosi = tx_buf[i][b];
            repeat (HALF) @(negedge clk);
            rx_buf[i][b] = miso;
            sck = p;
            repeat (2) @(negedge clk);
            m = miso;
            repeat (HALF-2) @(negedge clk);
            if (miso !== m) edge_bad = 1'b1;
         end
      end
      oe_during = miso_oe;
      cs = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         check(1'b0, "watchdog", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < 8; k++) res_data[k*10 +: 10] = 10'((37*k + 'h2A5) & 'h3FF);
      for (int k = 0; k < 3; k++) mdl[k] = 8'h00;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(miso == 0 && miso_oe == 0 && !wr_stb && !rd_stb, "R1 outputs", {miso, miso_oe}, 0);
      check(chan_sel == 0 && start_addr == 0 && mode_sel == 0, "R1 ctrl", {chan_sel, start_addr, mode_sel}, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R3 R5 R6: idle-low write burst into the control bytes
      tx_buf[0] = 8'h91; tx_buf[1] = 8'h05; tx_buf[2] = 8'hA3; tx_buf[3] = 8'h3C;
      push_wr(17, 8'h05); push_wr(18, 8'hA3); push_wr(19, 8'h3C);
      xfer(1'b0, 4, -1);
      check(!edge_bad, "R3 miso edge", edge_bad, 0);
      check(oe_during, "R10 oe high", oe_during, 1);
      check(miso_oe == 0 && miso == 0, "R10 idle", {miso_oe, miso}, 0);
      check(chan_sel == 8'h05 && start_addr == 8'hA3 && mode_sel == 8'h3C, "R6 ctrl ports",
            {chan_sel, start_addr, mode_sel}, 24'h05A33C);

      // R2 R4 R7: idle-high read back, junk on mosi ignored
      tx_buf[0] = 8'h11; tx_buf[1] = 8'hFF; tx_buf[2] = 8'hFF; tx_buf[3] = 8'hFF;
      rd_cnt = 0;
      xfer(1'b1, 4, -1);
      check(!edge_bad, "R4 miso edge", edge_bad, 0);
      for (int i = 1; i < 4; i++)
         check(rx_buf[i] == exp_rd(16 + i), "R2 R7 read data", rx_buf[i], exp_rd(16 + i));
      check(rd_cnt == 4, "R7 read strobes", rd_cnt, 4);

      // R8: walk across result, status, control and unmapped space
      tx_buf[0] = 8'h06;
      for (int i = 1; i < 16; i++) tx_buf[i] = 8'h00;
      xfer(1'b0, 16, -1);
      for (int i = 1; i < 16; i++)
         check(rx_buf[i] == exp_rd(5 + i), "R8 map read", rx_buf[i], exp_rd(5 + i));

      // R4 R8: idle-high writes into read-only space have no effect
      tx_buf[0] = 8'h85; tx_buf[1] = 8'h11; tx_buf[2] = 8'h22;
      push_wr(5, 8'h11); push_wr(6, 8'h22);
      xfer(1'b1, 3, -1);
      tx_buf[0] = 8'h90; tx_buf[1] = 8'hEE;
      push_wr(16, 8'hEE);
      xfer(1'b1, 2, -1);
      tx_buf[0] = 8'h05;
      for (int i = 1; i < 13; i++) tx_buf[i] = 8'h00;
      xfer(1'b1, 13, -1);
      for (int i = 1; i < 13; i++)
         check(rx_buf[i] == exp_rd(4 + i), "R8 read-only", rx_buf[i], exp_rd(4 + i));

      // R9: abort mid-byte, then a fresh transfer
      tx_buf[0] = 8'h91; tx_buf[1] = 8'h77;
      xfer(1'b1, 2, 5);
      check(chan_sel == 8'h05, "R9 no partial write", chan_sel, 8'h05);
      tx_buf[0] = 8'h11; tx_buf[1] = 8'h00;
      xfer(1'b0, 2, -1);
      check(rx_buf[1] == 8'h05, "R9 fresh frame", rx_buf[1], 8'h05);

      repeat (10) @(negedge clk);
      check(exp_q.size() == 0, "R6 missing writes", exp_q.size(), 0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule